// File: doc/BRIEF.md
# Composable Multi-RAM Transfer Mapper

This block connects a sequential word stream to a bank of up to 64 small local RAMs that are presented as one logical memory. A transfer is opened with a descriptor that carries a 16-bit starting local address, a length in bytes, the number of RAMs taking part and two mode bits. The block splits the length into RAM-sized words (DATA_W/8 bytes each). For each word it drives a RAM index, a per-RAM address and a read or write strobe on one shared RAM port.

Two compositions are chosen at run time. In linear composition the RAMs are stacked, which gives a deeper memory: the upper part of the logical address picks the RAM and the lower part is the address inside it. In interleaved composition successive words rotate across the RAMs, which gives a wider logical word. A fill moves words from the input stream into the RAMs. A drain reads words out of the RAMs onto the output stream. Both directions use the same mapping. A malformed descriptor is refused with a one-cycle error pulse and never touches the RAMs.

Top module: `mrx_mapper`

## Requirements
- R1: A descriptor is taken only in a cycle where `start_vld` and `start_rdy` are both high. `start_rdy` is low from the cycle after a valid descriptor is taken until the transfer ends. A descriptor presented while `start_rdy` is low has no effect: no `err`, no extra RAM access.
- R2: With `scatter`=1, word k (counted from 0) goes to RAM index k mod N at address (start_addr + floor(k/N)) mod 2^16. `ram_sel` is the binary RAM index, 0 to N-1.
- R3: With `scatter`=0, the logical address is L = (start_addr + k) mod 2^16. `ram_sel` = (L >> RAM_AW) mod 64 and `ram_addr` = L mod 2^RAM_AW (RAM_AW defaults to 8), so a transfer that crosses a 2^RAM_AW boundary continues in the next RAM at address 0.
- R4: `num_rams` (7 bits) accepts N from 1 to 64. With N=64 interleaved, word 64 returns to RAM 0 at the next address. N=1 keeps every word in RAM 0.
- R5: When `drain`=0 (fill), every word accepted on `in_vld`/`in_rdy` is written in that same cycle (`ram_we`=1, `ram_wdata`=`in_data`). Exactly byte_cnt/(DATA_W/8) words are accepted. `in_rdy` is high exactly while a fill is in progress.
- R6: When `drain`=1, reads are issued with `ram_re` at the mapped addresses. `ram_rdata` is taken one cycle after `ram_re`. The words leave on `out_vld`/`out_rdy` in issue order, and `out_data` holds steady while `out_vld` is high and `out_rdy` is low.
- R7: `done` is a one-cycle pulse in the cycle after the last word is written (fill) or handed off on the output stream (drain). `start_rdy` is high in that cycle.
- R8: A descriptor with a byte count that is zero or not a multiple of DATA_W/8 (4 by default), or with N=0 or N>64, is refused. `err` pulses for one cycle in the next cycle, no RAM access follows, and `start_rdy` stays high.
- R9: `ram_we` and `ram_re` are never high in the same cycle, and `in_rdy` is never high together with `out_vld`.
- R10: While reset is held, `start_rdy` is 1 and `in_rdy`, `out_vld`, `ram_we`, `ram_re`, `done` and `err` are 0.
- R11: A descriptor held on the start port while a transfer ends is taken in the same cycle as that transfer's `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_vld | input | 1 | Descriptor valid |
| start_rdy | output | 1 | Block idle, descriptor can be taken |
| start_addr | input | LADDR_W (16) | Starting local address |
| byte_cnt | input | CNT_W (16) | Transfer length in bytes |
| num_rams | input | NR_W (7) | Number of RAMs N, 1 to 64 |
| scatter | input | 1 | 1 = interleaved, 0 = linear |
| drain | input | 1 | 1 = RAMs to stream, 0 = stream to RAMs |
| in_vld | input | 1 | Fill word valid |
| in_rdy | output | 1 | Fill word accepted |
| in_data | input | DATA_W (32) | Fill word |
| out_vld | output | 1 | Drain word valid |
| out_rdy | input | 1 | Drain word taken |
| out_data | output | DATA_W (32) | Drain word |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_sel | output | SEL_W (6) | RAM index |
| ram_addr | output | LADDR_W (16) | Address inside the selected RAM |
| ram_wdata | output | DATA_W (32) | RAM write data |
| ram_rdata | input | DATA_W (32) | RAM read data, valid one cycle after ram_re |
| done | output | 1 | Transfer complete pulse |
| err | output | 1 | Descriptor refused pulse |

## Verification
Two functions can fall in the same cycle. The first is the completion of one transfer, seen as the `done` pulse. The second is the taking of the next descriptor. To provoke this, the bench holds a second descriptor on the start port while a short fill finishes, so it is taken in the very cycle `done` rises. The model then checks that `done`, `start_rdy` and the first access of the new transfer each land in their own cycle. The same concurrency is exercised inside a drain, where a word leaves on the output stream in the same cycle as the next read is issued under a throttled `out_rdy`. The in-order data check judges whether that overlap drops or repeats a word.

// File: rtl/mrx_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the multi-RAM transfer mapper.
package mrx_pkg;
    // How the RAMs are composed into one logical memory.
    typedef enum logic {
        MAP_LINEAR  = 1'b0,
        MAP_SCATTER = 1'b1
    } map_mode_e;

    // Direction of a transfer.
    typedef enum logic {
        DIR_FILL  = 1'b0,
        DIR_DRAIN = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/mrx_desc_chk.sv
`timescale 1ns/1ps
// Descriptor validation.
// Purpose: decides whether a descriptor is acceptable and gives its length
//          in RAM words.
// Assumes: a word is 2**WB_LG bytes; N must lie in 1..MAX_RAMS.
module mrx_desc_chk #(
    parameter int CNT_W    = 16,
    parameter int NR_W     = 7,
    parameter int MAX_RAMS = 64,
    parameter int WB_LG    = 2,
    localparam int WCNT_W  = CNT_W - WB_LG
) (
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic [NR_W-1:0]   num_rams,
    output logic              ok,
    output logic [WCNT_W-1:0] words
);
    logic misaligned;
    logic zero_len;
    logic bad_n;

    // Classify the descriptor fields.
    always_comb begin
        misaligned = |byte_cnt[WB_LG-1:0];
        zero_len   = (byte_cnt == '0);
        bad_n      = (num_rams == '0) || (num_rams > NR_W'(MAX_RAMS));
        ok         = !misaligned && !zero_len && !bad_n;
        words      = byte_cnt[CNT_W-1:WB_LG];
    end
endmodule

// File: rtl/mrx_addr_gen.sv
`timescale 1ns/1ps
// Address generator.
// Purpose: holds the running position of a transfer and maps it to a RAM
//          index and an address inside that RAM, for either composition.
// Assumes: load and step never coincide; N is already validated.
module mrx_addr_gen
    import mrx_pkg::*;
#(
    parameter int LADDR_W = 16,
    parameter int SEL_W   = 6,
    parameter int NR_W    = 7,
    parameter int RAM_AW  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [LADDR_W-1:0] start_addr,
    input  logic [NR_W-1:0]    num_rams,
    input  logic               scatter,
    output logic [SEL_W-1:0]   sel,
    output logic [LADDR_W-1:0] addr
);
    map_mode_e          mode_q;
    logic [NR_W-1:0]    nr_q;
    logic [LADDR_W-1:0] lin_q;
    logic [SEL_W-1:0]   sc_idx_q;
    logic [LADDR_W-1:0] sc_addr_q;
    logic [SEL_W-1:0]   lin_sel;
    logic [LADDR_W-1:0] lin_off;
    logic               sc_wrap;

    // Split the linear logical address into RAM index and RAM offset.
    if (RAM_AW < LADDR_W) begin : g_split
        localparam logic [LADDR_W-1:0] OFF_MASK = LADDR_W'((1 << RAM_AW) - 1);
        assign lin_sel = SEL_W'(lin_q >> RAM_AW);
        assign lin_off = lin_q & OFF_MASK;
    end else begin : g_whole
        assign lin_sel = '0;
        assign lin_off = lin_q;
    end

    // Last RAM of the interleave ring reached.
    assign sc_wrap = (NR_W'(sc_idx_q) + NR_W'(1)) == nr_q;

    // Load the start position or advance by one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MAP_LINEAR;
            nr_q      <= '0;
            lin_q     <= '0;
            sc_idx_q  <= '0;
            sc_addr_q <= '0;
        end else if (load) begin
            mode_q    <= map_mode_e'(scatter);
            nr_q      <= num_rams;
            lin_q     <= start_addr;
            sc_idx_q  <= '0;
            sc_addr_q <= start_addr;
        end else if (step) begin
            lin_q <= lin_q + LADDR_W'(1);
            if (sc_wrap) begin
                sc_idx_q  <= '0;
                sc_addr_q <= sc_addr_q + LADDR_W'(1);
            end else begin
                sc_idx_q  <= sc_idx_q + SEL_W'(1);
            end
        end
    end

    // Present the mapping of the current word.
    always_comb begin
        if (mode_q == MAP_SCATTER) begin
            sel  = sc_idx_q;
            addr = sc_addr_q;
        end else begin
            sel  = lin_sel;
            addr = lin_off;
        end
    end
endmodule

// File: rtl/mrx_drain_buf.sv
`timescale 1ns/1ps
// Drain output stage.
// Purpose: captures read data one cycle after a read and holds it on the
//          output stream until it is taken.
// Assumes: the RAM returns data exactly one cycle after the read strobe.
module mrx_drain_buf #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic              out_rdy,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data,
    output logic              can_issue
);
    logic rd_pend_q;

    // A new read may start when nothing is in flight and the slot frees.
    assign can_issue = !rd_pend_q && (!out_vld || out_rdy);

    // Track the read in flight and the word waiting on the stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q <= 1'b0;
            out_vld   <= 1'b0;
            out_data  <= '0;
        end else begin
            rd_pend_q <= rd_issue;
            if (rd_pend_q) begin
                out_vld  <= 1'b1;
                out_data <= ram_rdata;
            end else if (out_vld && out_rdy) begin
                out_vld  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/mrx_mapper.sv
`timescale 1ns/1ps
// Composable multi-RAM transfer mapper (top).
// Purpose: takes a transfer descriptor, splits its byte length into RAM
//          words and steers each word to a RAM index and address, in fill
//          (stream to RAMs) or drain (RAMs to stream) direction.
// Assumes: one shared RAM port with one-cycle read latency; descriptors
//          fit the composed capacity.
module mrx_mapper
    import mrx_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int LADDR_W  = 16,
    parameter int CNT_W    = 16,
    parameter int MAX_RAMS = 64,
    parameter int RAM_AW   = 8,
    localparam int WB_LG   = $clog2(DATA_W / 8),
    localparam int SEL_W   = $clog2(MAX_RAMS),
    localparam int NR_W    = SEL_W + 1,
    localparam int WCNT_W  = CNT_W - WB_LG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_vld,
    output logic               start_rdy,
    input  logic [LADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]   byte_cnt,
    input  logic [NR_W-1:0]    num_rams,
    input  logic               scatter,
    input  logic               drain,
    input  logic               in_vld,
    output logic               in_rdy,
    input  logic [DATA_W-1:0]  in_data,
    output logic               out_vld,
    input  logic               out_rdy,
    output logic [DATA_W-1:0]  out_data,
    output logic               ram_we,
    output logic               ram_re,
    output logic [SEL_W-1:0]   ram_sel,
    output logic [LADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0]  ram_wdata,
    input  logic [DATA_W-1:0]  ram_rdata,
    output logic               done,
    output logic               err
);
    logic              desc_ok;
    logic [WCNT_W-1:0] desc_words;
    logic              busy_q;
    xfer_dir_e         dir_q;
    logic [WCNT_W-1:0] iss_left_q;
    logic [WCNT_W-1:0] cmp_left_q;
    logic              accept;
    logic              load;
    logic              fill_fire;
    logic              rd_issue;
    logic              can_issue;
    logic              step;
    logic              cmp_ev;

    mrx_desc_chk #(
        .CNT_W(CNT_W), .NR_W(NR_W), .MAX_RAMS(MAX_RAMS), .WB_LG(WB_LG)
    ) u_desc (
        .byte_cnt(byte_cnt), .num_rams(num_rams),
        .ok(desc_ok), .words(desc_words)
    );

    // Handshake and per-cycle events.
    always_comb begin
        start_rdy = !busy_q;
        accept    = start_vld && !busy_q;
        load      = accept && desc_ok;
        in_rdy    = busy_q && (dir_q == DIR_FILL);
        fill_fire = in_rdy && in_vld;
        rd_issue  = busy_q && (dir_q == DIR_DRAIN) && (iss_left_q != '0) && can_issue;
        step      = fill_fire || rd_issue;
        cmp_ev    = fill_fire || (out_vld && out_rdy);
        ram_we    = fill_fire;
        ram_re    = rd_issue;
        ram_wdata = in_data;
    end

    mrx_addr_gen #(
        .LADDR_W(LADDR_W), .SEL_W(SEL_W), .NR_W(NR_W), .RAM_AW(RAM_AW)
    ) u_agen (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .start_addr(start_addr), .num_rams(num_rams), .scatter(scatter),
        .sel(ram_sel), .addr(ram_addr)
    );

    mrx_drain_buf #(
        .DATA_W(DATA_W)
    ) u_dbuf (
        .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .ram_rdata(ram_rdata),
        .out_rdy(out_rdy), .out_vld(out_vld), .out_data(out_data),
        .can_issue(can_issue)
    );

    // Transfer state: word counters, completion and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            dir_q      <= DIR_FILL;
            iss_left_q <= '0;
            cmp_left_q <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= cmp_ev && (cmp_left_q == WCNT_W'(1));
            err  <= accept && !desc_ok;
            if (load) begin
                busy_q     <= 1'b1;
                dir_q      <= xfer_dir_e'(drain);
                iss_left_q <= desc_words;
                cmp_left_q <= desc_words;
            end else begin
                if (step) begin
                    iss_left_q <= iss_left_q - WCNT_W'(1);
                end
                if (cmp_ev) begin
                    cmp_left_q <= cmp_left_q - WCNT_W'(1);
                    if (cmp_left_q == WCNT_W'(1)) begin
                        busy_q <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mrx_chk.sv
`timescale 1ns/1ps
// Assertion checker for mrx_mapper, attached with bind.
// Purpose: watches the ports for handshake, exclusivity and pulse rules.
// Assumes: synchronous active-low reset on rst_n.
module mrx_chk #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 6,
    parameter int NR_W   = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_vld,
    input logic              start_rdy,
    input logic [NR_W-1:0]   num_rams,
    input logic              scatter,
    input logic              in_rdy,
    input logic              out_vld,
    input logic              out_rdy,
    input logic [DATA_W-1:0] out_data,
    input logic              ram_we,
    input logic              ram_re,
    input logic [SEL_W-1:0]  ram_sel,
    input logic              done,
    input logic              err
);
    logic [NR_W-1:0] nr_q;
    logic            sc_q;

    // Remember N and the composition of the latest descriptor taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nr_q <= '0;
            sc_q <= 1'b0;
        end else if (start_vld && start_rdy) begin
            nr_q <= num_rams;
            sc_q <= scatter;
        end
    end

    p_busy_no_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_vld && !start_rdy) |=> !err);
    p_sel_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ram_we || ram_re) && sc_q) |-> ({1'b0, ram_sel} < nr_q));
    p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_rdy) |=> (out_vld && $stable(out_data)));
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> start_rdy);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!ram_we && !ram_re && start_rdy));
    p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(start_vld && start_rdy));
    p_one_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));
    p_rdy_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_rdy && out_vld));
endmodule

bind mrx_mapper mrx_chk #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .NR_W(NR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_rdy(start_rdy),
    .num_rams(num_rams), .scatter(scatter), .in_rdy(in_rdy),
    .out_vld(out_vld), .out_rdy(out_rdy), .out_data(out_data),
    .ram_we(ram_we), .ram_re(ram_re), .ram_sel(ram_sel),
    .done(done), .err(err)
);

// File: tb/mrx_mapper_tb.sv
`timescale 1ns/1ps
// Bench: behavioural RAM, queue-based reference model compared every cycle.
module mrx_mapper_tb;
    localparam int RAM_AW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_vld = 1'b0;
    logic        start_rdy;
    logic [15:0] start_addr = '0;
    logic [15:0] byte_cnt = '0;
    logic [6:0]  num_rams = '0;
    logic        scatter = 1'b0;
    logic        drain = 1'b0;
    logic        in_vld = 1'b0;
    logic        in_rdy;
    logic [31:0] in_data = '0;
    logic        out_vld;
    logic        out_rdy = 1'b1;
    logic [31:0] out_data;
    logic        ram_we, ram_re;
    logic [5:0]  ram_sel;
    logic [15:0] ram_addr;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = '0;
    logic        done, err;

    always #10 clk = ~clk;

    mrx_mapper #(.RAM_AW(RAM_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_rdy(start_rdy),
        .start_addr(start_addr), .byte_cnt(byte_cnt), .num_rams(num_rams),
        .scatter(scatter), .drain(drain), .in_vld(in_vld), .in_rdy(in_rdy),
        .in_data(in_data), .out_vld(out_vld), .out_rdy(out_rdy),
        .out_data(out_data), .ram_we(ram_we), .ram_re(ram_re),
        .ram_sel(ram_sel), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .done(done), .err(err)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int overlap_cnt = 0;
    string map_tag = "R2";

    logic [31:0] mem [int];
    int          exp_sel_q[$];
    int          exp_addr_q[$];
    logic [31:0] exp_data_q[$];
    bit          mbusy = 0;
    bit          mdrain = 0;
    int          mrem = 0;
    bit          exp_done = 0;
    bit          exp_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Behavioural RAM bank: write now, read data one cycle later.
    always @(posedge clk) begin
        if (ram_we) mem[int'(ram_sel) * 65536 + int'(ram_addr)] = ram_wdata;
        if (ram_re) begin
            if (mem.exists(int'(ram_sel) * 65536 + int'(ram_addr)))
                ram_rdata <= mem[int'(ram_sel) * 65536 + int'(ram_addr)];
            else
                ram_rdata <= 32'hDEAD_BEEF;
        end
    end

    // Output-ready pattern.
    initial forever begin
        @(negedge clk);
        cyc++;
        out_rdy = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end

    // Reference model, sampled mid-cycle and compared every cycle.
    always begin
        @(negedge clk);
        #5;
        if (rst_n) begin
            bit nxt_done;
            bit nxt_err;
            nxt_done = 0;
            nxt_err  = 0;
            chk(start_rdy == !mbusy, "R1", "start_rdy", start_rdy, !mbusy);
            chk(done == exp_done, "R7", "done", done, exp_done);
            chk(err == exp_err, "R8", "err", err, exp_err);
            chk(in_rdy == (mbusy && !mdrain), "R5", "in_rdy", in_rdy, mbusy && !mdrain);
            chk(!(ram_we && ram_re), "R9", "we&re", {ram_we, ram_re}, 0);
            if ((ram_we || ram_re || out_vld) && !mbusy)
                chk(0, "R8", "access while idle", {ram_we, ram_re, out_vld}, 0);
            if (done && start_vld && start_rdy) overlap_cnt++;
            if (in_vld && in_rdy)
                chk(ram_we && ram_wdata == in_data, "R5", "write of accepted word",
                    ram_wdata, in_data);
            if (ram_we || ram_re) begin
                if (exp_sel_q.size() == 0) begin
                    chk(0, map_tag, "unexpected access", ram_addr, 0);
                end else begin
                    int es;
                    int ea;
                    es = exp_sel_q.pop_front();
                    ea = exp_addr_q.pop_front();
                    chk(int'(ram_sel) == es, map_tag, "ram_sel", ram_sel, es);
                    chk(int'(ram_addr) == ea, map_tag, "ram_addr", ram_addr, ea);
                end
            end
            if (ram_re) begin
                int k;
                k = int'(ram_sel) * 65536 + int'(ram_addr);
                exp_data_q.push_back(mem.exists(k) ? mem[k] : 32'hDEAD_BEEF);
            end
            if (ram_we) begin
                mrem--;
                if (mrem == 0) begin nxt_done = 1; mbusy = 0; end
            end
            if (out_vld && out_rdy) begin
                if (exp_data_q.size() == 0) begin
                    chk(0, "R6", "unexpected out word", out_data, 0);
                end else begin
                    logic [31:0] ed;
                    ed = exp_data_q.pop_front();
                    chk(out_data == ed, "R6", "out_data", out_data, ed);
                end
                mrem--;
                if (mrem == 0) begin nxt_done = 1; mbusy = 0; end
            end
            if (start_vld && start_rdy) begin
                int nb;
                int nn;
                nb = int'(byte_cnt);
                nn = int'(num_rams);
                if ((nb % 4) != 0 || nb == 0 || nn == 0 || nn > 64) begin
                    nxt_err = 1;
                end else begin
                    mbusy  = 1;
                    mdrain = drain;
                    mrem   = nb / 4;
                    for (int k = 0; k < nb / 4; k++) begin
                        if (scatter) begin
                            exp_sel_q.push_back(k % nn);
                            exp_addr_q.push_back((int'(start_addr) + k / nn) & 16'hFFFF);
                        end else begin
                            int la;
                            la = (int'(start_addr) + k) & 16'hFFFF;
                            exp_sel_q.push_back((la >> RAM_AW) & 63);
                            exp_addr_q.push_back(la & ((1 << RAM_AW) - 1));
                        end
                    end
                end
            end
            exp_done = nxt_done;
            exp_err  = nxt_err;
        end
    end

    task automatic start_xfer(input int sa, input int nb, input int n,
                              input bit sc, input bit dr);
        start_vld  = 1'b1;
        start_addr = 16'(sa);
        byte_cnt   = 16'(nb);
        num_rams   = 7'(n);
        scatter    = sc;
        drain      = dr;
        while (!start_rdy) @(negedge clk);
        @(negedge clk);
        start_vld  = 1'b0;
    endtask

    task automatic feed(input int nw, input int seed, input bit gaps);
        for (int i = 0; i < nw; i++) begin
            if (gaps && (i % 3) == 1) begin
                in_vld = 1'b0;
                @(negedge clk);
            end
            in_vld  = 1'b1;
            in_data = 32'hA500_0000 + 32'(seed * 4096 + i);
            while (!in_rdy) @(negedge clk);
            @(negedge clk);
        end
        in_vld = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(start_rdy && !mbusy)) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #5;
        // R10: reset values
        chk(start_rdy == 1'b1, "R10", "start_rdy in reset", start_rdy, 1);
        chk({in_rdy, out_vld, ram_we, ram_re, done, err} == 6'b0, "R10",
            "outputs in reset", {in_rdy, out_vld, ram_we, ram_re, done, err}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2, R5, R1: interleaved fill over 4 RAMs, poke while busy
        map_tag = "R2";
        fork
            start_xfer(16'h0010, 40, 4, 1, 0);
            feed(10, 1, 1);
            begin
                repeat (5) @(negedge clk);
                start_vld = 1'b1; byte_cnt = 16'd6; num_rams = 7'd0;
                @(negedge clk);
                start_vld = 1'b0;
            end
        join
        wait_idle();

        // R2, R6: interleaved drain with throttled output
        rdy_mode = 1;
        start_xfer(16'h0010, 40, 4, 1, 1);
        wait_idle();
        rdy_mode = 0;

        // R3: linear fill and drain crossing a RAM boundary
        map_tag = "R3";
        fork
            start_xfer(16'h00FE, 16, 3, 0, 0);
            feed(4, 2, 0);
        join
        wait_idle();
        rdy_mode = 1;
        start_xfer(16'h00FE, 16, 3, 0, 1);
        wait_idle();
        rdy_mode = 0;

        // R8: refused descriptors
        start_xfer(16'h0000, 6, 4, 1, 0);
        repeat (2) @(negedge clk);
        start_xfer(16'h0000, 0, 4, 1, 0);
        repeat (2) @(negedge clk);
        start_xfer(16'h0000, 8, 0, 0, 0);
        repeat (2) @(negedge clk);
        start_xfer(16'h0000, 8, 65, 1, 1);
        repeat (3) @(negedge clk);

        // R4: 64 RAMs interleaved, wraps back to RAM 0
        map_tag = "R4";
        fork
            start_xfer(16'h0200, 280, 64, 1, 0);
            feed(70, 3, 0);
        join
        wait_idle();
        start_xfer(16'h0200, 280, 64, 1, 1);
        wait_idle();

        // R4: single RAM, local address wraps at 16 bits
        fork
            start_xfer(16'hFFFE, 20, 1, 1, 0);
            feed(5, 4, 1);
        join
        wait_idle();

        // R11: descriptor held across the end of a fill
        map_tag = "R2";
        fork
            start_xfer(16'h0040, 8, 2, 1, 0);
            feed(2, 5, 0);
            begin
                repeat (2) @(negedge clk);
                start_xfer(16'h0040, 8, 2, 1, 1);
            end
        join
        wait_idle();
        chk(overlap_cnt > 0, "R11", "descriptor taken with done", overlap_cnt, 1);

        summary();
        $finish;
    end
endmodule